// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine

This block is a small register-mapped CRC-16 calculator for an infrared link controller. Software clears the engine through the control register and then writes one byte per bus write into the data register. Each write folds one byte into a running CRC and bumps a 12-bit item counter. Software can read the counter back from the control register and the finished checksum from the result register at any time.

The checksum is the reflected CCITT CRC used by the asynchronous infrared framing. The polynomial is x^16+x^12+x^5+1 with the bit-reversed constant 0x8408. Bytes are processed least significant bit first from a seed of 0xFFFF, and the result register shows the one's complement of the running value. With these settings, the power-up self-test sequence 0xCC, 0xF5, 0xF1, 0xA7 yields 0x51DF. The bus is 16 bits wide and carries one access per cycle. `addr_i` selects 0 = control/count, 1 = data in, 2 = result, and 3 = unmapped.

Top module: `irda_crc_engine`

## Requirements
- R1: After `rst_ni` is released, the count reads 0 and the result register reads 0x0000, because the seed 0xFFFF is shown inverted.
- R2: A write to address 0 with bit 15 set clears the count to 0 and reloads the seed. The result register then reads 0x0000 again.
- R3: A write to address 0 with bit 15 clear changes neither the count nor the CRC.
- R4: A read of address 0 returns the count in bits 11:0, with bits 15:12 reading zero.
- R5: Each write to address 1 raises the count by one. Only bits 7:0 of the written word are used as the byte, and bits 15:8 have no effect on the CRC.
- R6: Each byte is folded in least significant bit first: the byte is XORed into the low bits, then the value is shifted right once per bit, with 0x8408 XORed in whenever the bit shifted out is 1. The seed is 0xFFFF, and the result register returns the running value XOR 0xFFFF.
- R7: After a clear, the bytes 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and a result of 0x51DF.
- R8: The count saturates at 0xFFF: further data writes leave it at 0xFFF while the CRC keeps updating.
- R9: Reads have no side effects. A write to address 2 or 3 changes nothing. A read of address 3 returns 0, and `rdata_o` is 0 whenever `rd_i` is low.
- R10: A data write takes effect in one clock, so a read in the cycle after the write returns the updated count and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register select: 0 control/count, 1 data, 2 result |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` while `rd_i` is high |

## Verification
The bench sweeps all 256 byte values from a fresh seed and puts non-zero upper bits on each write. A design that reflected the wrong way, used a different seed, forgot the output inversion or let bits 15:8 leak into the byte disagrees on most of those values. A counter that wraps instead of saturating reads 0x000 after 4096 writes, and the bench drives past that point. Control writes without bit 15, writes to the result and unmapped addresses, and repeated reads are each followed by a read-back of both count and result, which exposes a design that clears or advances on the wrong access.

// File: rtl/irda_crc_pkg.sv
package irda_crc_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned CNT_W   = 12;
  localparam int unsigned IN_W    = 12;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CLR_BIT = 15;

  localparam logic [REG_W-1:0] POLY_REV = 16'h8408;
  localparam logic [REG_W-1:0] SEED     = 16'hFFFF;
  localparam logic [REG_W-1:0] XOR_OUT  = 16'hFFFF;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DIN  = 2'd1,
    ADDR_DOUT = 2'd2,
    ADDR_NONE = 2'd3
  } crc_addr_e;
endpackage

// File: rtl/crc_bus_decode.sv
module crc_bus_decode
  import irda_crc_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter int unsigned IW = IN_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned CB = CLR_BIT
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              clr_o,
  output logic              feed_o,
  output logic [BW-1:0]     byte_o
);
  logic [IW-1:0] din_masked;
  logic          unused_bits;

  assign din_masked  = wdata_i[IW-1:0];
  assign byte_o      = din_masked[BW-1:0];
  assign clr_o       = wr_i && (addr_i == ADDR_CTRL) && wdata_i[CB];
  assign feed_o      = wr_i && (addr_i == ADDR_DIN);
  assign unused_bits = ^{wdata_i[DW-1:IW], din_masked[IW-1:BW]};
endmodule

// File: rtl/crc_byte_core.sv
module crc_byte_core
  import irda_crc_pkg::*;
#(
  parameter int unsigned       W    = REG_W,
  parameter int unsigned       BW   = BYTE_W,
  parameter logic [REG_W-1:0]  POLY = POLY_REV,
  parameter logic [REG_W-1:0]  INIT = SEED
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          feed_i,
  input  logic [BW-1:0] byte_i,
  output logic [W-1:0]  crc_o
);
  logic [W-1:0] crc_q;
  logic [W-1:0] stage [BW+1];

  // LSB-first serial division, one stage per bit of the byte
  assign stage[0] = crc_q ^ {{(W-BW){1'b0}}, byte_i};
  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY[W-1:0])
                                    : (stage[i] >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT[W-1:0];
    else if (clr_i)  crc_q <= INIT[W-1:0];
    else if (feed_i) crc_q <= stage[BW];
  end

  assign crc_o = crc_q;

  a_r2_seed_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == INIT[W-1:0]);
  a_r9_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !feed_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_item_counter.sv
module crc_item_counter
  import irda_crc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          feed_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (feed_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_i && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_count_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  a_r9_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !feed_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irda_crc_engine.sv
module irda_crc_engine
  import irda_crc_pkg::*;
#(
  parameter int unsigned      DW   = REG_W,
  parameter int unsigned      CW   = CNT_W,
  parameter logic [REG_W-1:0] POLY = POLY_REV,
  parameter logic [REG_W-1:0] INIT = SEED,
  parameter logic [REG_W-1:0] XORO = XOR_OUT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic              clr;
  logic              feed;
  logic [BYTE_W-1:0] din_byte;
  logic [DW-1:0]     crc_run;
  logic [CW-1:0]     cnt;

  crc_bus_decode #(.DW(DW), .IW(IN_W), .BW(BYTE_W), .CB(CLR_BIT)) u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .clr_o   (clr),
    .feed_o  (feed),
    .byte_o  (din_byte)
  );

  crc_byte_core #(.W(DW), .BW(BYTE_W), .POLY(POLY), .INIT(INIT)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .feed_i (feed),
    .byte_i (din_byte),
    .crc_o  (crc_run)
  );

  crc_item_counter #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .feed_i (feed),
    .cnt_o  (cnt)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_CTRL: rdata_o = {{(DW-CW){1'b0}}, cnt};
        ADDR_DOUT: rdata_o = crc_run ^ XORO[DW-1:0];
        default:   rdata_o = '0;
      endcase
    end
  end

  a_r4_count_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_CTRL) |-> rdata_o[DW-1:CW] == '0);
  a_r9_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
  a_r1_reset_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> crc_run == INIT[DW-1:0] && cnt == '0);
endmodule

// File: tb/sim_irda_crc_engine.sv
`timescale 1ns/1ps
module sim_irda_crc_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_crc;
  int          m_cnt;

  always #10 clk_i = ~clk_i;

  irda_crc_engine u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [15:0] upd(logic [15:0] c, logic [7:0] b);
    logic [15:0] v = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) v = v[0] ? ((v >> 1) ^ 16'h8408) : (v >> 1);
    return v;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_i = 1'b1; addr_i = a;
    #2 v = rdata_o;
    rd_i = 1'b0;
    #1;
  endtask

  task automatic clear();
    wr(2'd0, 16'h8000);
    m_crc = 16'hFFFF; m_cnt = 0;
  endtask

  task automatic feed(logic [7:0] b, logic [7:0] hi);
    wr(2'd1, {hi, b});
    m_crc = upd(m_crc, b);
    if (m_cnt < 4095) m_cnt++;
  endtask

  task automatic check_both(string req);
    logic [15:0] v;
    rd(2'd0, v); chk(req, v, 16'(m_cnt));
    rd(2'd2, v); chk(req, v, ~m_crc);
  endtask

  initial begin
    #4000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    logic [7:0]  lf;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    m_crc = 16'hFFFF; m_cnt = 0;
    // R1 reset state
    check_both("R1");

    // R7 self-test, R10 read right after each write
    clear();
    feed(8'hCC, 8'h00); check_both("R10");
    feed(8'hF5, 8'h00); check_both("R10");
    feed(8'hF1, 8'h00); check_both("R10");
    feed(8'hA7, 8'h00);
    rd(2'd0, v); chk("R7 count", v, 16'd4);
    rd(2'd2, v); chk("R7 result", v, 16'h51DF);

    // R6/R5 exhaustive single-byte sweep with upper bits set
    for (int b = 0; b < 256; b++) begin
      clear();
      feed(8'(b), 8'(b * 7 + 3));
      rd(2'd0, v); chk("R5 count", v, 16'd1);
      rd(2'd2, v); chk("R6 sweep", v, ~upd(16'hFFFF, 8'(b)));
    end

    // R3 control write without bit 15
    clear();
    feed(8'h5A, 8'hFF); feed(8'h3C, 8'h80);
    wr(2'd0, 16'h7FFF);
    check_both("R3");

    // R9 writes to result and unmapped, repeated reads, idle bus
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'hFFFF);
    check_both("R9");
    rd(2'd2, v); rd(2'd2, v2); chk("R9 reread", v2, v);
    rd(2'd3, v); chk("R9 unmapped", v, 16'h0000);
    #2 chk("R9 idle", rdata_o, 16'h0000);

    // R2 clear after data
    wr(2'd0, 16'h8000);
    rd(2'd0, v); chk("R2 count", v, 16'h0000);
    rd(2'd2, v); chk("R2 result", v, 16'h0000);
    m_crc = 16'hFFFF; m_cnt = 0;

    // R6 long pseudo-random stream
    lf = 8'h1D;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      feed(lf, ~lf);
      if (i % 60 == 59) check_both("R6 stream");
    end

    // R8 saturation, R4 upper bits zero
    clear();
    for (int i = 0; i < 4100; i++) feed(8'(i), 8'h00);
    rd(2'd0, v); chk("R8 sat", v, 16'h0FFF);
    chk("R4 upper", {4'h0, v[11:0]}, v);
    rd(2'd2, v); chk("R8 crc", v, ~m_crc);
    feed(8'h77, 8'h00);
    check_both("R8 hold");
    clear();
    check_both("R2 after sat");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule